// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register Bank

This block lets one processor interrupt another. It holds one 32-bit register for each hart, and those registers sit at consecutive word offsets on a simple 32-bit register bus. A write to a hart's register sets or clears that hart's software interrupt request, and each request drives a dedicated output line to the core.

A build-time parameter selects the level. At machine level, a read returns the hart's pending bit. At supervisor level, every read returns zero, because the core keeps its own writable copy of that pending bit. A register offset is valid only when it is word aligned and falls inside the configured hart range. An access to a register slot beyond the configured harts raises a one-cycle error pulse.

Top module: `hart_swi_bank`

## Requirements
- R1: After reset, every pending bit and every interrupt output is 0.
- R2: A write to offset 4*k (k < NUM_HARTS) with wdata bit 0 equal to 1 drives irq_o[k] high on the clock edge that accepts the write.
- R3: A write to offset 4*k with wdata bit 0 equal to 0 drives irq_o[k] low on that same edge. Bits 31:1 of the write data have no effect.
- R4: A write to one hart's offset leaves the other harts' interrupt outputs unchanged.
- R5: When SUPERVISOR is 0, a read of offset 4*k returns irq_o[k] in rdata bit 0, with bits 31:1 at 0. Read data is valid one cycle after the request.
- R6: When SUPERVISOR is 1, every read returns 0.
- R7: An access whose address bits 1:0 are not 00 changes no state, and a read of such an address returns 0.
- R8: An access at or beyond offset 4*NUM_HARTS but below 4*MAX_HARTS changes no state, returns 0 on a read, and pulses err_o for exactly one cycle after the request.
- R9: hart_id_o reports FIRST_HART plus the register index of the last accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after request |
| err_o | output | 1 | Out-of-range hart access pulse |
| hart_id_o | output | 32 | Global hart number of last accepted access |
| irq_o | output | NUM_HARTS | Software interrupt lines |

## Verification
A pending flop that is stuck or decoded to the wrong hart is visible on irq_o on the same edge that accepts the write. In machine mode, the same fault is also visible on rdata_o one cycle later. An incorrect range check shows up as a missing or spurious err_o pulse in the cycle after the request, or as an interrupt line that changes when it should not. The bench runs two instances, one per level, so a read that ignores the mode parameter is caught as well.

// File: rtl/hart_swi_bank.sv
module hart_swi_bank #(
  parameter int NUM_HARTS  = 4,
  parameter int MAX_HARTS  = 16,
  parameter int FIRST_HART = 0,
  parameter bit SUPERVISOR = 1'b0,
  parameter int AW         = $clog2(MAX_HARTS) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic                 err_o,
  output logic [31:0]          hart_id_o,
  output logic [NUM_HARTS-1:0] irq_o
);
  localparam int IW = AW - 2;

  logic [NUM_HARTS-1:0] pend_q;
  logic [IW-1:0]        idx;
  logic                 aligned, in_range, hit;

  assign idx      = addr_i[AW-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign in_range = ({1'b0, idx} < (IW+1)'(NUM_HARTS));
  assign hit      = req_i && aligned && in_range;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[h] <= 1'b0;
      else if (hit && we_i && idx == IW'(h)) pend_q[h] <= wdata_i[0];
    end
  end

  assign irq_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o   <= '0;
      err_o     <= 1'b0;
      hart_id_o <= 32'(FIRST_HART);
    end else begin
      err_o   <= req_i && aligned && !in_range;
      rdata_o <= '0;
      if (hit) begin
        hart_id_o <= 32'(FIRST_HART) + 32'(idx);
        if (!we_i && !SUPERVISOR) rdata_o <= {31'b0, pend_q[idx]};
      end
    end
  end
endmodule

// File: rtl/hart_swi_bank_chk.sv
module hart_swi_bank_chk #(
  parameter int NUM_HARTS  = 4,
  parameter bit SUPERVISOR = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_i,
  input logic                 we_i,
  input logic [31:0]          rdata_o,
  input logic                 err_o,
  input logic [NUM_HARTS-1:0] irq_o
);
  // R5
  read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[31:1] == 31'b0);
  // R6
  sup_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    SUPERVISOR |-> rdata_o == 32'b0);
  // R8
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o || $past(req_i));
  // R8
  err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(req_i));
  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && we_i) |=> $stable(irq_o));
  // R4
  irq_one_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_o ^ $past(irq_o)) <= 1);
endmodule

bind hart_swi_bank hart_swi_bank_chk #(.NUM_HARTS(NUM_HARTS), .SUPERVISOR(SUPERVISOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i),
  .rdata_o(rdata_o), .err_o(err_o), .irq_o(irq_o));

// File: tb/hart_swi_bank_tb.sv
module hart_swi_bank_tb;
  localparam int N = 4, AW = 6, FH = 8;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s, hid, hid_s;
  logic err, err_s;
  logic [N-1:0] irq, irq_s;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hart_swi_bank #(.NUM_HARTS(N), .MAX_HARTS(16), .FIRST_HART(FH), .SUPERVISOR(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .err_o(err), .hart_id_o(hid), .irq_o(irq));

  hart_swi_bank #(.NUM_HARTS(N), .MAX_HARTS(16), .FIRST_HART(FH), .SUPERVISOR(1'b1)) u_sup (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_s), .err_o(err_s), .hart_id_o(hid_s), .irq_o(irq_s));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // drive at negedge, one request cycle; sample after next posedge (negedge)
  task automatic access(bit w, logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 irq sup", 32'(irq_s), 0);
    chk("R1 err", 32'(err), 0);
  endtask

  task automatic t_set_clear;
    access(1, 6'd4, 32'h1);
    chk("R2 set hart1", 32'(irq), 32'b0010);
    chk("R2 set hart1 sup", 32'(irq_s), 32'b0010);
    access(1, 6'd12, 32'hFFFF_FFFF);
    chk("R2 set hart3", 32'(irq), 32'b1010);
    access(1, 6'd4, 32'hFFFF_FFFE);
    chk("R3 clear with upper bits", 32'(irq), 32'b1000);
    chk("R4 others kept", 32'(irq[3]), 1);
  endtask

  task automatic t_read;
    access(0, 6'd12, 0);
    chk("R5 read pending", rdata, 32'h1);
    chk("R9 hart id", hid, FH + 3);
    chk("R6 sup read", rdata_s, 0);
    access(0, 6'd0, 0);
    chk("R5 read idle", rdata, 0);
    chk("R9 hart id 0", hid, FH);
  endtask

  task automatic t_misaligned;
    access(1, 6'd1, 32'h1);
    chk("R7 no state", 32'(irq), 32'b1000);
    access(0, 6'd14, 0);
    chk("R7 read zero", rdata, 0);
    chk("R7 no err", 32'(err), 0);
  endtask

  task automatic t_range;
    access(1, 6'd16, 32'h1);
    chk("R8 err pulse", 32'(err), 1);
    chk("R8 no state", 32'(irq), 32'b1000);
    @(negedge clk);
    chk("R8 err single", 32'(err), 0);
    access(0, 6'd60, 0);
    chk("R8 read zero", rdata, 0);
    chk("R8 err on read", 32'(err), 1);
    chk("R9 id unchanged", hid, FH);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_read();
    t_misaligned();
    t_range();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule